// File: doc/BRIEF.md
# Timer Event Output Pin Generator

This block drives a general-purpose timer's external pin from the counter's overflow and compare-match strobes. It does nothing while the pin is set as an input. A 2-bit trigger selector decides which strobes count as events: none, overflow only, or both overflow and match. A style bit decides what an event does. In toggle style, an event inverts the pin. In pulse style, an event drives a pulse that lasts one clock and has the opposite polarity of the programmed default level.

When no trigger is selected, or when the timer is stopped, the pin is held at the default level. Any change to these fields takes effect at the next clock edge. The counter and the capture path are outside this block. They supply the strobes and the control fields, and a timer core instantiates the block next to its counter.

Top module: `evpin_gen`

## Requirements
- R1: The trigger selector `trig_sel` is decoded as 0 = no events, 1 = overflow only, 2 = overflow and match. The value 3 behaves exactly like 0.
- R2: In toggle style (`pulse_sel` = 0), while running with an active trigger, each qualifying event inverts `pin_out` at the next clock edge. With no event, the pin holds its level.
- R3: In pulse style (`pulse_sel` = 1), while running with an active trigger, a qualifying event drives `pin_out` to the inverse of `dflt_lvl` for exactly one clock. On every other cycle the pin equals `dflt_lvl`.
- R4: With `trig_sel` = 1, a match strobe without an overflow strobe leaves `pin_out` unchanged.
- R5: With trigger selector 0 or 3, `pin_out` equals `dflt_lvl` after the next clock edge. Strobes have no effect.
- R6: While `run_en` = 0, `pin_out` equals `dflt_lvl` after the next clock edge, whatever the strobes and the style.
- R7: While `pin_dir_out` = 0 (pin is an input), `pin_out` keeps its value regardless of every other input.
- R8: In trigger mode 2, an overflow strobe and a match strobe in the same cycle count as one event. With the default `MERGE_COINC` = 1, the pin toggles once.
- R9: After reset, `pin_out` equals the parameter `RST_LVL` (default 0).
- R10: A change of `dflt_lvl` while the pin is forced appears on `pin_out` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ovf | input | 1 | Counter overflow strobe, one cycle |
| ev_mat | input | 1 | Compare-match strobe, one cycle |
| run_en | input | 1 | Timer running |
| trig_sel | input | 2 | Trigger selector (0 none, 1 overflow, 2 both, 3 none) |
| pulse_sel | input | 1 | Event style: 0 toggle, 1 one-clock pulse |
| dflt_lvl | input | 1 | Default pin level |
| pin_dir_out | input | 1 | 1 = pin is an output and may be driven |
| pin_out | output | 1 | Registered pin level |

## Verification
The checker tests on every cycle the relation between each cycle's inputs and the next pin level. It covers holding while the pin is an input, forcing to the default when stopped or untriggered, the polarity of pulses and the idle level, inversion on events in toggle style, and ignored match strobes in overflow-only mode. Some behaviours are shown only by the bench's scenarios: multi-cycle toggle sequences that return to the start level, coincident strobes, a default-level change that follows a forced period, and the resumption of toggling from a held level after the direction changes back. The bench compares the pin against a behavioural model on every clock, including over a long pseudo-random mix of strobes and field changes.

// File: rtl/evpin_pkg.sv
package evpin_pkg;

   typedef enum logic [1:0] {
      TRIG_OFF  = 2'd0,
      TRIG_OVF  = 2'd1,
      TRIG_BOTH = 2'd2,
      TRIG_RSV  = 2'd3
   } trig_mode_e;

   function automatic logic trig_active(input trig_mode_e m);
      return (m == TRIG_OVF) || (m == TRIG_BOTH);
   endfunction

   function automatic logic trig_takes_match(input trig_mode_e m);
      return (m == TRIG_BOTH);
   endfunction

endpackage

// File: rtl/evpin_qual.sv
module evpin_qual
   import evpin_pkg::*;
#(
   parameter int MERGE_COINC = 1,
   localparam int CNT_W = 2
) (
   input  trig_mode_e       mode,
   input  logic             ovf,
   input  logic             mat,
   output logic [CNT_W-1:0] n_evt
);

   logic ovf_hit;
   logic mat_hit;

   always_comb begin
      ovf_hit = ovf && trig_active(mode);
      mat_hit = mat && trig_takes_match(mode);
   end

   generate
      if (MERGE_COINC != 0) begin : g_merge
         assign n_evt = {{(CNT_W-1){1'b0}}, ovf_hit | mat_hit};
      end else begin : g_separate
         assign n_evt = {{(CNT_W-1){1'b0}}, ovf_hit} + {{(CNT_W-1){1'b0}}, mat_hit};
      end
   endgenerate

endmodule

// File: rtl/evpin_next.sv
module evpin_next
   import evpin_pkg::*;
#(
   localparam int CNT_W = 2
) (
   input  logic             cur,
   input  logic             dflt,
   input  logic             run,
   input  logic             out_en,
   input  logic             pulse,
   input  trig_mode_e       mode,
   input  logic [CNT_W-1:0] n_evt,
   output logic             nxt
);

   always_comb begin
      nxt = cur;
      if (out_en) begin
         if (!trig_active(mode) || !run) begin
            nxt = dflt;
         end else if (pulse) begin
            nxt = (n_evt != '0) ? ~dflt : dflt;
         end else begin
            nxt = cur ^ n_evt[0];
         end
      end
   end

endmodule

// File: rtl/evpin_gen.sv
module evpin_gen
   import evpin_pkg::*;
#(
   parameter bit RST_LVL     = 1'b0,
   parameter int MERGE_COINC = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_ovf,
   input  logic       ev_mat,
   input  logic       run_en,
   input  logic [1:0] trig_sel,
   input  logic       pulse_sel,
   input  logic       dflt_lvl,
   input  logic       pin_dir_out,
   output logic       pin_out
);

   localparam int CNT_W = 2;

   initial begin
      assert (MERGE_COINC == 0 || MERGE_COINC == 1)
         else $error("evpin_gen: MERGE_COINC must be 0 or 1");
   end

   trig_mode_e       mode;
   logic [CNT_W-1:0] n_evt;
   logic             pin_q;
   logic             pin_d;

   assign mode = trig_mode_e'(trig_sel);

   evpin_qual #(
      .MERGE_COINC (MERGE_COINC)
   ) u_qual (
      .mode  (mode),
      .ovf   (ev_ovf),
      .mat   (ev_mat),
      .n_evt (n_evt)
   );

   evpin_next u_next (
      .cur    (pin_q),
      .dflt   (dflt_lvl),
      .run    (run_en),
      .out_en (pin_dir_out),
      .pulse  (pulse_sel),
      .mode   (mode),
      .n_evt  (n_evt),
      .nxt    (pin_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= RST_LVL;
      end else begin
         pin_q <= pin_d;
      end
   end

   assign pin_out = pin_q;

endmodule

// File: rtl/evpin_chk.sv
module evpin_chk #(
   parameter int MERGE_COINC = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_ovf,
   input logic       ev_mat,
   input logic       run_en,
   input logic [1:0] trig_sel,
   input logic       pulse_sel,
   input logic       dflt_lvl,
   input logic       pin_dir_out,
   input logic       pin_out
);

   logic act;
   logic hit;
   assign act = (trig_sel == 2'd1) || (trig_sel == 2'd2);
   assign hit = (ev_ovf && act) || (ev_mat && trig_sel == 2'd2);

   AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_dir_out |=> pin_out == $past(pin_out)); // R7

   AST_FORCE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_dir_out && (!act || !run_en)) |=> pin_out == $past(dflt_lvl)); // R5

   AST_STOP_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_dir_out && !run_en) |=> pin_out == $past(dflt_lvl)); // R6

   AST_PULSE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_dir_out && run_en && act && pulse_sel && hit) |=> pin_out == !$past(dflt_lvl)); // R3

   AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_dir_out && run_en && act && pulse_sel && !hit) |=> pin_out == $past(dflt_lvl)); // R3

   AST_TOGGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_dir_out && run_en && act && !pulse_sel && !hit) |=> $stable(pin_out)); // R2

   AST_MATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_dir_out && run_en && trig_sel == 2'd1 && !pulse_sel && !ev_ovf) |=> $stable(pin_out)); // R4

   generate
      if (MERGE_COINC != 0) begin : g_merge_chk
         AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_dir_out && run_en && act && !pulse_sel && hit) |=> pin_out != $past(pin_out)); // R8
      end
   endgenerate

endmodule

bind evpin_gen evpin_chk #(.MERGE_COINC(MERGE_COINC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ev_ovf      (ev_ovf),
   .ev_mat      (ev_mat),
   .run_en      (run_en),
   .trig_sel    (trig_sel),
   .pulse_sel   (pulse_sel),
   .dflt_lvl    (dflt_lvl),
   .pin_dir_out (pin_dir_out),
   .pin_out     (pin_out)
);

// File: tb/evpin_gen_bench.sv
module evpin_gen_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_ovf = 1'b0;
   logic       ev_mat = 1'b0;
   logic       run_en = 1'b0;
   logic [1:0] trig_sel = 2'd0;
   logic       pulse_sel = 1'b0;
   logic       dflt_lvl = 1'b0;
   logic       pin_dir_out = 1'b0;
   logic       pin_out;

   int    n_chk = 0;
   int    n_err = 0;
   int    cyc_cnt = 0;
   bit    checking = 1'b0;
   bit    done = 1'b0;
   bit    exp_pin = 1'b0;
   string cur_req = "R9";

   always #5 clk = ~clk;

   evpin_gen u_evpin_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev_ovf      (ev_ovf),
      .ev_mat      (ev_mat),
      .run_en      (run_en),
      .trig_sel    (trig_sel),
      .pulse_sel   (pulse_sel),
      .dflt_lvl    (dflt_lvl),
      .pin_dir_out (pin_dir_out),
      .pin_out     (pin_out)
   );

   // behavioural reference: pin level after each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_pin = 1'b0;
      end else if (pin_dir_out) begin
         int  m;
         bit  live;
         bit  event_seen;
         m = int'(trig_sel);
         live = (m == 1) || (m == 2);
         event_seen = live && (ev_ovf || (m == 2 && ev_mat));
         if (!live || !run_en)
            exp_pin = dflt_lvl;
         else if (pulse_sel)
            exp_pin = event_seen ? !dflt_lvl : dflt_lvl;
         else if (event_seen)
            exp_pin = !exp_pin;
      end
   end

   always @(negedge clk) begin
      if (checking) begin
         n_chk++;
         if (pin_out !== exp_pin) begin
            n_err++;
            $display("FAIL %s: pin_out=%0b expected=%0b at cycle %0d",
                     cur_req, pin_out, exp_pin, cyc_cnt);
         end
      end
   end

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 100000 && !done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic step(input bit o, input bit m);
      ev_ovf = o;
      ev_mat = m;
      @(negedge clk);
      ev_ovf = 1'b0;
      ev_mat = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R9";
      checking = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R7: pin is an input, strobes and mode changes leave it at 0
      cur_req = "R7";
      pin_dir_out = 1'b0; run_en = 1'b1; trig_sel = 2'd2; dflt_lvl = 1'b1;
      step(1, 0); step(0, 1); step(1, 1); idle(2);

      // R5: mode none forces default, strobes ignored
      cur_req = "R5";
      pin_dir_out = 1'b1; trig_sel = 2'd0; dflt_lvl = 1'b1;
      step(1, 1); step(1, 0); idle(2);

      // R1: mode 3 acts as none
      cur_req = "R1";
      trig_sel = 2'd3; dflt_lvl = 1'b0;
      step(1, 0); step(0, 1); idle(2);

      // R2: toggle on overflow in mode 1
      cur_req = "R2";
      trig_sel = 2'd1; pulse_sel = 1'b0;
      step(1, 0); idle(2); step(1, 0); step(1, 0); step(1, 0); idle(2);

      // R4: match ignored in mode 1
      cur_req = "R4";
      step(0, 1); step(0, 1); idle(1); step(0, 1);

      // R2: match toggles in mode 2
      cur_req = "R2";
      trig_sel = 2'd2;
      step(0, 1); idle(1); step(1, 0); idle(1);

      // R8: coincident strobes count once
      cur_req = "R8";
      step(1, 1); idle(1); step(1, 1); idle(1);

      // R7: hold a toggled level while input, then resume
      cur_req = "R7";
      step(1, 0);
      pin_dir_out = 1'b0;
      step(1, 0); step(0, 1); idle(1);
      pin_dir_out = 1'b1;
      step(1, 0); idle(1);

      // R3: pulse style, default 0 then 1
      cur_req = "R3";
      pulse_sel = 1'b1; dflt_lvl = 1'b0;
      idle(2); step(1, 0); idle(2); step(0, 1); step(1, 0); idle(1);
      dflt_lvl = 1'b1;
      idle(1); step(0, 1); idle(2); step(1, 1); idle(1);

      // R6: stopped forces default in both styles
      cur_req = "R6";
      run_en = 1'b0; dflt_lvl = 1'b0;
      step(1, 1); idle(1);
      pulse_sel = 1'b0;
      step(1, 0); idle(1);

      // R10: default change while forced
      cur_req = "R10";
      dflt_lvl = 1'b1; idle(2);
      dflt_lvl = 1'b0; idle(1);
      run_en = 1'b1; trig_sel = 2'd0;
      dflt_lvl = 1'b1; idle(2);

      // R2: pseudo-random mix compared every clock
      cur_req = "R2";
      begin
         int unsigned lfsr = 32'h1ACE_5EED;
         for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (lfsr[9:6] == 4'd0) trig_sel = lfsr[11:10];
            if (lfsr[15:12] == 4'd0) pulse_sel = lfsr[16];
            if (lfsr[20:17] == 4'd0) dflt_lvl = lfsr[21];
            if (lfsr[25:22] == 4'd0) run_en = lfsr[26];
            if (lfsr[30:27] == 4'd0) pin_dir_out = lfsr[31];
            step(lfsr[2], lfsr[4]);
         end
      end

      checking = 1'b0;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule